// File: doc/BRIEF.md
# Reverse-Channel Run-Length Expander

This block sits between the receive side of a parallel-port reverse channel and a host-side byte FIFO. Every byte it takes in arrives with a tag that marks it as a command byte or a data byte. The physical link marks command bytes by holding its busy line negated. The block turns this tagged stream into a plain byte stream, and it expands run-length-encoded data on the way.

A command byte with its top bit set carries a 7-bit channel address. The block latches that address and pulses a strobe. A command byte with its top bit clear carries a 7-bit repeat count. The count applies only to the next data byte, which the block emits count+1 times. Input and output both use valid/ready handshakes. The block holds input ready low while it still has copies to deliver, and it stops in place when the output side stalls.

Top module: `rle_expander`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets outValid, chanStrobe and chanAddr to 0 and discards any armed repeat count. The first data byte after reset is therefore emitted once.
- R2: A data byte (inIsCmd=0) that arrives with no repeat count armed is emitted exactly once.
- R3: A command byte with bit 7 = 0 arms a repeat count N taken from bits 6:0. The next data byte is then emitted N+1 times. N=0 gives one copy, N=1 gives two copies and N=127 gives 128 copies.
- R4: An armed count is used up by the first data byte that follows it. Later data bytes are emitted once each.
- R5: When a second count command arrives before any data byte, its count replaces the earlier one.
- R6: A command byte with bit 7 = 1 loads bits 6:0 into chanAddr and drives chanStrobe high for exactly the one cycle after it is accepted. It also discards any armed count and adds no byte to the output stream.
- R7: inReady is low whenever outValid is high. inReady is high when no copies remain to be delivered.
- R8: While outValid is high and outReady is low, outValid stays high and outByte holds its value at the next edge.
- R9: While outReady stays high, the copies of one run are delivered on consecutive cycles. A run of N+1 copies keeps outValid high for exactly N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte is present |
| inIsCmd | input | 1 | 1 = command byte, 0 = data byte |
| inByte | input | 8 | Received byte |
| inReady | output | 1 | Block accepts a byte at this edge |
| outValid | output | 1 | outByte holds a copy to deliver |
| outByte | output | 8 | Expanded data byte |
| outReady | input | 1 | Consumer takes the copy at this edge |
| chanAddr | output | 7 | Last channel address received |
| chanStrobe | output | 1 | One-cycle pulse after an address command |

## Verification
The assertions assume that the input side follows the valid/ready rule: a byte counts as taken only on an edge where inValid and inReady are both high. They also assume that the consumer samples outByte only on edges where outValid and outReady are both high. The stimulus presents each byte and holds it until inReady is seen high, then drops inValid. outReady is drawn at random on every cycle, except during one run where it is held high so that back-to-back delivery can be timed. Reset is applied once in the middle of the run, while a count is armed, to show that the count is discarded.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef struct packed {
    logic loadData;
    logic loadCount;
    logic loadChan;
    logic emit;
    logic finish;
  } rle_strb_t;
endpackage

// File: rtl/rle_ctrl.sv
module rle_ctrl
  import rle_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inIsCmd,
  input  logic      cmdTop,
  input  logic      outReady,
  input  logic      busy,
  input  logic      lastCopy,
  output logic      inReady,
  output rle_strb_t strb
);
  logic accept;

  always_comb begin
    inReady        = !busy;
    accept         = inValid && !busy;
    strb.loadData  = accept && !inIsCmd;
    strb.loadCount = accept && inIsCmd && !cmdTop;
    strb.loadChan  = accept && inIsCmd && cmdTop;
    strb.emit      = busy && outReady;
    strb.finish    = busy && outReady && lastCopy;
  end

  // R7: once a byte is taken, further input is refused until the run ends
  p_refuse_after_load_r7: assert property (@(posedge clk) disable iff (rst)
    strb.loadData |=> !inReady);
endmodule

// File: rtl/rle_datapath.sv
module rle_datapath
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W - 1,
  localparam int REM_W = CNT_W + 1
)(
  input  logic              clk,
  input  logic              rst,
  input  rle_strb_t         strb,
  input  logic [DATA_W-1:0] inByte,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outByte,
  output logic              lastCopy,
  output logic [CNT_W-1:0]  chanAddr,
  output logic              chanStrobe
);
  logic [DATA_W-1:0] dataReg;
  logic [REM_W-1:0]  remaining;
  logic [CNT_W-1:0]  countReg;
  logic              pendFlag;
  logic [CNT_W-1:0]  chanReg;
  logic              strobeReg;
  logic              validReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg   <= '0;
      remaining <= '0;
      countReg  <= '0;
      pendFlag  <= 1'b0;
      chanReg   <= '0;
      strobeReg <= 1'b0;
      validReg  <= 1'b0;
    end else begin
      strobeReg <= strb.loadChan;
      if (strb.loadData) begin
        dataReg   <= inByte;
        remaining <= pendFlag ? ({1'b0, countReg} + REM_W'(1)) : REM_W'(1);
        pendFlag  <= 1'b0;
        validReg  <= 1'b1;
      end else if (strb.emit) begin
        remaining <= remaining - REM_W'(1);
        if (strb.finish) validReg <= 1'b0;
      end
      if (strb.loadCount) begin
        countReg <= inByte[CNT_W-1:0];
        pendFlag <= 1'b1;
      end
      if (strb.loadChan) begin
        chanReg  <= inByte[CNT_W-1:0];
        pendFlag <= 1'b0;
      end
    end
  end

  assign outValid   = validReg;
  assign outByte    = dataReg;
  assign lastCopy   = (remaining == REM_W'(1));
  assign chanAddr   = chanReg;
  assign chanStrobe = strobeReg;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && !chanStrobe && chanAddr == '0));
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    strb.loadData |-> !outValid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outByte)));
  p_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && !lastCopy) |=> outValid);
  p_chan_load_r6: assert property (@(posedge clk) disable iff (rst)
    strb.loadChan |=> (chanStrobe && chanAddr == $past(inByte[CNT_W-1:0])));
  p_data_starts_r2: assert property (@(posedge clk) disable iff (rst)
    strb.loadData |=> (outValid && outByte == $past(inByte)));
endmodule

// File: rtl/rle_expander.sv
module rle_expander
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W - 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inIsCmd,
  input  logic [DATA_W-1:0] inByte,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outByte,
  input  logic              outReady,
  output logic [CNT_W-1:0]  chanAddr,
  output logic              chanStrobe
);
  rle_strb_t strb;
  logic      lastCopy;

  rle_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inIsCmd(inIsCmd),
    .cmdTop(inByte[DATA_W-1]), .outReady(outReady), .busy(outValid),
    .lastCopy(lastCopy), .inReady(inReady), .strb(strb)
  );

  rle_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .inByte(inByte), .outReady(outReady),
    .outValid(outValid), .outByte(outByte), .lastCopy(lastCopy),
    .chanAddr(chanAddr), .chanStrobe(chanStrobe)
  );
endmodule

// File: tb/sim_rle_expander.sv
module sim_rle_expander;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0, inIsCmd = 1'b0, outReady = 1'b0;
  logic [7:0] inByte = '0;
  logic       inReady, outValid, chanStrobe;
  logic [7:0] outByte;
  logic [6:0] chanAddr;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] expQ[$];
  bit   mPend = 0;
  int   mCount = 0;
  bit   forceReady = 0;
  int   validCycles = 0;
  bit   prevStall = 0;
  logic [7:0] prevByte = '0;

  always #4 clk = ~clk;

  rle_expander u0 (.clk(clk), .rst(rst), .inValid(inValid), .inIsCmd(inIsCmd),
    .inByte(inByte), .inReady(inReady), .outValid(outValid), .outByte(outByte),
    .outReady(outReady), .chanAddr(chanAddr), .chanStrobe(chanStrobe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(0, "watchdog", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (!rst) begin
      if (prevStall) begin
        check(outValid && outByte == prevByte, "R8 hold", int'(outByte), int'(prevByte));
      end
      if (outValid) begin
        validCycles++;
        check(!inReady, "R7 ready low while valid", int'(inReady), 0);
      end
      outReady = forceReady ? 1'b1 : (($urandom % 4) != 0);
      prevStall = outValid && !outReady;
      prevByte  = outByte;
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(0, "R3 R4 extra copy", int'(outByte), -1);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(outByte == e, "R2 R3 R4 R5 outByte", int'(outByte), int'(e));
        end
      end
    end else prevStall = 0;
  end

  task automatic send(input bit cmd, input logic [7:0] b);
    inValid = 1'b1; inIsCmd = cmd; inByte = b;
    while (!inReady) @(negedge clk);
    if (cmd && b[7]) mPend = 0;
    else if (cmd) begin mPend = 1; mCount = int'(b[6:0]); end
    else begin
      for (int i = 0; i < (mPend ? mCount + 1 : 1); i++) expQ.push_back(b);
      mPend = 0;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0 || outValid) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!outValid && expQ.size() == 0, "R4 no leftover copies", int'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!outValid && !chanStrobe && chanAddr == 0, "R1 reset state", int'(outValid), 0);
    check(inReady, "R7 ready when idle", int'(inReady), 1);
    // R2 plain bytes
    send(0, 8'h3C); send(0, 8'hA5); drain();
    // R3 counts 0, 1, 126, 127; R4 following byte once
    send(1, 8'h00); send(0, 8'h11); send(0, 8'h12); drain();
    send(1, 8'h01); send(0, 8'h22); send(0, 8'h23); drain();
    send(1, 8'h7E); send(0, 8'h33); send(0, 8'h34); drain();
    send(1, 8'h7F); send(0, 8'hF4); send(0, 8'h45); drain();
    // R5 later count replaces earlier
    send(1, 8'h05); send(1, 8'h02); send(0, 8'h56); drain();
    // R6 address command
    inValid = 1'b1; inIsCmd = 1'b1; inByte = 8'hD3;
    while (!inReady) @(negedge clk);
    mPend = 0;
    @(negedge clk); inValid = 1'b0;
    check(chanStrobe && chanAddr == 7'h53, "R6 strobe and address", int'(chanAddr), 'h53);
    @(negedge clk);
    check(!chanStrobe, "R6 strobe one cycle", int'(chanStrobe), 0);
    send(1, 8'h04); send(1, 8'h81); send(0, 8'h67); drain();
    check(chanAddr == 7'h01, "R6 second address", int'(chanAddr), 1);
    // R9 back-to-back delivery
    forceReady = 1;
    send(1, 8'h7E);
    validCycles = 0;
    send(0, 8'h78); drain();
    check(validCycles == 127, "R9 run length in cycles", validCycles, 127);
    forceReady = 0;
    // R1 reset discards armed count
    send(1, 8'h09);
    rst = 1'b1; mPend = 0; expQ.delete();
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!outValid && chanAddr == 0, "R1 reset clears", int'(chanAddr), 0);
    send(0, 8'h9A); drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule